// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two single-bit timing inputs, a divided reference and a divided oscillator feedback, both sampled on the system clock. A rising edge on either input arms one of two flags: "up" for the reference and "down" for the feedback. Once both flags are armed they stay armed for a programmable number of clock cycles and then drop together. Because of this hold, a locked loop still emits a pair of short up/down pulses every comparison period, which keeps the charge pump out of its dead zone. A flag can stay armed while its own input produces another edge, so the detector handles phase errors of up to a full period in either direction.

The flags drive a two-bit pump command. The upper bit enables the output driver and the lower bit gives the level, so the command is high, low, or high-impedance. A lock monitor measures how many cycles each comparison event spends with only one flag set. An event is good when that count falls within a programmable window. After four good events in a row, the lock output rests high and drops low for the length of each pump pulse. A synchronous counter-reset input clears the flags, the hold timer and the lock state.

Top module: `pfd_lock_top`

## Requirements
- R1: A rising edge on `ref_in` sets the up flag, which is visible on `up_o` in the cycle after the edge. While up alone is set, `pump_o` = 2'b11 (drive enabled, level high).
- R2: A rising edge on `fb_in` sets the down flag, which is visible on `dn_o` in the cycle after the edge. While down alone is set, `pump_o` = 2'b10 (drive enabled, level low).
- R3: When neither flag is set, or both are set, `pump_o` = 2'b00 (bit 1 = drive enable low, so the output is high-impedance).
- R4: Once both flags are set, they remain set for exactly `dly_cfg`+1 cycles and then clear in the same cycle. This gives a minimum-width pulse even when the two edges coincide.
- R5: A new rising edge that arrives in the cycle where the flags clear re-arms its flag. A repeated edge on an input whose flag is already set leaves that flag set.
- R6: `cnt_rst` high at a clock edge clears both flags and the lock state at that edge. An input edge seen during that same cycle is discarded and does not set its flag later.
- R7: An event is good when the number of cycles with exactly one flag set is ≤ `win_cfg`. After four consecutive good events, `lock_o` goes high in the cycle after the fourth event's flags clear.
- R8: While locked, `lock_o` is low in every cycle in which up or down is set, and high otherwise.
- R9: An event that is not good drops lock in the cycle after its flags clear and restarts the count of good events.
- R10: During and right after reset, `up_o`, `dn_o` and `lock_o` are 0 and `pump_o` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Divided reference, synchronous to clk |
| fb_in | input | 1 | Divided feedback, synchronous to clk |
| cnt_rst | input | 1 | Synchronous counter reset: clears flags and lock |
| dly_cfg | input | DLY_W | Hold cycles minus one once both flags are set |
| win_cfg | input | WIN_W | Largest one-sided width counted as a good event |
| up_o | output | 1 | Pump-up flag |
| dn_o | output | 1 | Pump-down flag |
| pump_o | output | 2 | {drive_en, level} pump command |
| lock_o | output | 1 | Lock indicator |

## Verification
Two collisions matter here. The first is a rising input edge in the same cycle that the hold timer clears both flags, where set must beat clear. The second is a counter reset arriving together with an input edge, where reset must win and the edge must not reappear later. The bench times its stimulus so that each edge lands on exactly the cycle the hold expires or the reset is applied. It then checks the flags and pump command over the following cycles against values it derives from the phase offset and the hold setting. A sweep over offsets from −4 to +4 cycles and hold settings 0 to 3 covers the ordinary cases, and a running count of good events predicts `lock_o`.

// File: rtl/pfd_pkg.sv
// Shared types for the phase-frequency detector.
package pfd_pkg;
    // Pump command: bit 1 enables the driver, bit 0 is the level.
    typedef enum logic [1:0] {
        PUMP_Z  = 2'b00,
        PUMP_DN = 2'b10,
        PUMP_UP = 2'b11
    } pump_e;
endpackage

// File: rtl/pfd_edge.sv
// Rising-edge detector for one input that is already synchronous to clk.
// Assumes sig_i meets setup to clk; rise_o is combinational from sig_i
// and the stored previous sample.
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    // Keep the previous sample so that a level change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    // Flag a 0-to-1 transition.
    always_comb rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
// Two-flag detector with delayed reset feedback. Each rising edge arms its flag.
// With both flags armed, a hold counter runs, and both flags clear together
// once it reaches dly_cfg. A set that falls in the clear cycle wins.
// Assumes synchronous rise inputs; cnt_rst takes priority over everything.
module pfd_core #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_rst,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic [DLY_W-1:0] dly_cfg,
    output logic             up_q,
    output logic             dn_q,
    output logic             done_o
);
    logic             both;
    logic             clr;
    logic [DLY_W-1:0] hold_q;

    // Decide when the hold has run its course.
    always_comb begin
        both   = up_q & dn_q;
        clr    = both && (hold_q == dly_cfg);
        done_o = clr & ~cnt_rst;
    end

    // Flags and hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_rst) begin
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
            hold_q <= '0;
        end else begin
            up_q   <= (up_q & ~clr) | ref_rise;
            dn_q   <= (dn_q & ~clr) | fb_rise;
            hold_q <= (both && !clr) ? hold_q + 1'b1 : '0;
        end
    end

    // R1: a reference edge arms the up flag.
    assert_ref_sets_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !cnt_rst) |=> up_q);
    // R2: a feedback edge arms the down flag.
    assert_fb_sets_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rise && !cnt_rst) |=> dn_q);
    // R4: with a nonzero hold, a fresh pair survives its first cycle.
    assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(up_q & dn_q) && dly_cfg != '0 && !cnt_rst) |=> (up_q && dn_q));
    // R6: counter reset empties both flags.
    assert_cnt_rst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_lock.sv
// Lock monitor. It counts the cycles of each event that have exactly one flag
// set and judges the event when the core signals done. After LOCK_N good events
// in a row it declares lock. lock_o is low while any flag is set.
// Assumes done_i is a single-cycle strobe from the core.
module pfd_lock #(
    parameter int WIN_W  = 4,
    parameter int LOCK_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_rst,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             done_i,
    input  logic [WIN_W-1:0] win_cfg,
    output logic             lock_o
);
    localparam int CW = $clog2(LOCK_N + 1);
    localparam logic [WIN_W:0] W_MAX = '1;

    logic [WIN_W:0] width_q;
    logic [CW-1:0]  good_q;
    logic           locked_q;
    logic           good;

    // Judge the finished event against the window.
    always_comb good = (width_q <= {1'b0, win_cfg});

    // One-sided width counter, restarted by each event end.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_rst)          width_q <= '0;
        else if (done_i)                width_q <= '0;
        else if ((up_i ^ dn_i) && width_q != W_MAX) width_q <= width_q + 1'b1;
    end

    // Consecutive-good counter and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_rst) begin
            good_q   <= '0;
            locked_q <= 1'b0;
        end else if (done_i) begin
            if (good) begin
                if (good_q != CW'(LOCK_N)) good_q <= good_q + 1'b1;
                locked_q <= (good_q >= CW'(LOCK_N - 1));
            end else begin
                good_q   <= '0;
                locked_q <= 1'b0;
            end
        end
    end

    // Show lock as high with low gaps during pump activity.
    always_comb lock_o = locked_q & ~(up_i | dn_i);

    // R7: lock can only appear right after an event is judged.
    assert_lock_from_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> $past(done_i));
    // R9: a bad event removes lock.
    assert_bad_drops_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !good && !cnt_rst) |=> !locked_q);
    // R6: counter reset removes lock.
    assert_rst_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> !locked_q);
endmodule

// File: rtl/pfd_lock_top.sv
// Phase-frequency detector top: edge detection, two-flag core, pump encoding
// and lock monitor. Inputs are assumed synchronous to clk; reset is
// synchronous active-low.
module pfd_lock_top #(
    parameter int DLY_W  = 4,
    parameter int WIN_W  = 4,
    parameter int LOCK_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             cnt_rst,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic [WIN_W-1:0] win_cfg,
    output logic             up_o,
    output logic             dn_o,
    output logic [1:0]       pump_o,
    output logic             lock_o
);
    import pfd_pkg::*;

    logic ref_rise, fb_rise, done;
    pump_e pump;

    pfd_edge u_ref_edge (.clk(clk), .rst_n(rst_n), .sig_i(ref_in), .rise_o(ref_rise));
    pfd_edge u_fb_edge  (.clk(clk), .rst_n(rst_n), .sig_i(fb_in),  .rise_o(fb_rise));

    pfd_core #(.DLY_W(DLY_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst),
        .ref_rise(ref_rise), .fb_rise(fb_rise), .dly_cfg(dly_cfg),
        .up_q(up_o), .dn_q(dn_o), .done_o(done)
    );

    pfd_lock #(.WIN_W(WIN_W), .LOCK_N(LOCK_N)) u_lock (
        .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst),
        .up_i(up_o), .dn_i(dn_o), .done_i(done), .win_cfg(win_cfg),
        .lock_o(lock_o)
    );

    // Map the flag pair onto the three-state pump command.
    always_comb begin
        case ({up_o, dn_o})
            2'b10:   pump = PUMP_UP;
            2'b01:   pump = PUMP_DN;
            default: pump = PUMP_Z;
        endcase
        pump_o = pump;
    end

    // R3: a driven output never coincides with a balanced flag pair.
    assert_z_when_balanced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o == dn_o) |-> !pump_o[1]);
    // R8: lock never shows during pump activity.
    assert_lock_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o || dn_o) |-> !lock_o);
endmodule

// File: tb/pfd_lock_top_tb.sv
`timescale 1ns/1ps
module pfd_lock_top_tb;
    logic       clk = 1'b0;
    logic       rst_n, ref_in, fb_in, cnt_rst;
    logic [3:0] dly_cfg, win_cfg;
    logic       up_o, dn_o, lock_o;
    logic [1:0] pump_o;

    int n_chk = 0;
    int n_bad = 0;
    int good_n = 0;
    bit lk = 0;

    always #2 clk = ~clk;

    pfd_lock_top u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .cnt_rst(cnt_rst), .dly_cfg(dly_cfg), .win_cfg(win_cfg),
        .up_o(up_o), .dn_o(dn_o), .pump_o(pump_o), .lock_o(lock_o)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare flags and pump command with an expected state.
    task automatic check_state(string tag, bit eu, bit ed);
        check({tag, " up"}, int'(up_o), int'(eu));
        check({tag, " dn"}, int'(dn_o), int'(ed));
        check({tag, " pump"}, int'(pump_o),
              (eu && !ed) ? 3 : (ed && !eu) ? 2 : 0);
    endtask

    // Bench lock model: update after an event of the given one-sided width.
    task automatic judge(int lead);
        if (lead <= int'(win_cfg)) begin
            if (good_n < 4) good_n++;
            lk = (good_n >= 4);
        end else begin
            good_n = 0;
            lk = 0;
        end
    endtask

    // One comparison event. d > 0: reference leads by d cycles; d < 0: feedback leads.
    task automatic run_pair(int d, string ltag);
        int lead = (d < 0) ? -d : d;
        int tr = (d < 0) ? -d : 0;
        int tf = (d < 0) ? 0 : d;
        int hold = int'(dly_cfg);
        for (int k = 0; k < lead + hold + 3; k++) begin
            ref_in = (k == tr);
            fb_in  = (k == tf);
            tick();
            if (k == lead + hold + 1) judge(lead);
            if (k < lead)
                check_state((d > 0) ? "R1" : "R2", d > 0, d < 0);
            else if (k <= lead + hold)
                check_state("R4", 1'b1, 1'b1);
            else
                check_state("R3", 1'b0, 1'b0);
            if (k <= lead + hold) check("R8 gap", int'(lock_o), 0);
            else                  check(ltag, int'(lock_o), int'(lk));
        end
        ref_in = 0; fb_in = 0;
    endtask

    task automatic pulse_cnt_rst();
        cnt_rst = 1; tick(); cnt_rst = 0;
        good_n = 0; lk = 0;
        check("R6 lock", int'(lock_o), 0);
        check_state("R6", 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; ref_in = 0; fb_in = 0; cnt_rst = 0;
        dly_cfg = 0; win_cfg = 0;
        repeat (3) tick();
        check_state("R10", 1'b0, 1'b0);
        check("R10 lock", int'(lock_o), 0);
        rst_n = 1;
        tick();
        check_state("R10", 1'b0, 1'b0);

        // Sweep of offsets and hold settings, window 0.
        for (int h = 0; h < 4; h++) begin
            dly_cfg = 4'(h);
            for (int d = -4; d <= 4; d++) run_pair(d, "R7");
        end

        // R5: edge coincides with clear, hold 1.
        pulse_cnt_rst();
        dly_cfg = 1;
        ref_in = 1; tick(); check_state("R1", 1, 0);
        ref_in = 0; tick(); check_state("R1", 1, 0);
        fb_in = 1;  tick(); check_state("R4", 1, 1);
        fb_in = 0;  tick(); check_state("R4", 1, 1);
        ref_in = 1; tick(); check_state("R5 set beats clear", 1, 0);
        ref_in = 0; tick(); check_state("R5", 1, 0);
        ref_in = 1; tick(); check_state("R5 repeat edge", 1, 0);
        ref_in = 0; fb_in = 1; tick(); check_state("R4", 1, 1);
        fb_in = 0;  tick(); check_state("R4", 1, 1);
        tick();     check_state("R3", 0, 0);

        // R6: counter reset coincides with an edge.
        ref_in = 1; cnt_rst = 1; tick(); check_state("R6 edge dropped", 0, 0);
        cnt_rst = 0; tick(); check_state("R6 no late set", 0, 0);
        tick(); check_state("R6 no late set", 0, 0);
        ref_in = 0; tick(); check_state("R3", 0, 0);

        // Lock acquisition with window 2.
        pulse_cnt_rst();
        win_cfg = 2;
        for (int i = 0; i < 4; i++) run_pair(1, "R7");
        check("R7 locked", int'(lock_o), 1);
        run_pair(-2, "R8");
        run_pair(0, "R8");
        run_pair(3, "R9");
        check("R9 unlocked", int'(lock_o), 0);
        for (int i = 0; i < 4; i++) run_pair(-1, "R7");
        check("R7 relocked", int'(lock_o), 1);
        pulse_cnt_rst();
        tick();
        check("R6 lock cleared", int'(lock_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule